// File: doc/BRIEF.md
# Shared Data-Memory Port Arbiter

This block lets a scalar core and a vector coprocessor share one 32-bit data-memory port. Each cycle it forwards at most one request, taken from one of the two masters, and only when the memory signals that it is ready. A small queue of source tags is filled in grant order. Memory responses return in order, and the tag at the head of the queue steers each response back to the master that issued the request.

The block also keeps memory ordering between the two masters. The vector side pulses an acceptance signal whenever it takes a vector load or store instruction. It also marks the final memory request of each such instruction. A registered count of vector instructions in flight rises in the cycle after acceptance. It falls when the response to the marked final request comes back. While the count is non-zero, scalar requests are held off. This covers the gap between acceptance and the first vector request, so a scalar read that follows a vector store cannot overtake it.

Top module: `dmem_arbiter`

## Requirements
- R1: After reset no vector instruction counts as pending and the tag queue is empty. A response arriving with an empty queue raises neither `s_rvalid` nor `v_rvalid`, and a lone scalar request is granted at once.
- R2: When a request is forwarded, `m_req` is high and `m_we`, `m_addr`, `m_wdata` and `m_be` equal the granted master's fields in the same cycle.
- R3: A grant (`s_gnt` or `v_gnt`) is given only in a cycle with `m_rdy` high, and never to both masters in one cycle.
- R4: With nothing pending, a lone scalar or lone vector request is granted. When both request together, the vector master is granted.
- R5: After `v_acc` is seen high at a clock edge, scalar requests get no grant until the cycle after the response to the vector request marked by `v_last` has returned.
- R6: The hold-off starts in the cycle right after `v_acc`. It stays in force in the cycles before the vector master has issued any request.
- R7: Responses are routed in grant order. The port chosen by the head tag sees `rvalid` high with `m_rdata`. The other port sees `rvalid` low and `rdata` zero.
- R8: Several accepted vector instructions are counted. The hold-off lasts until a `v_last` response has returned for each of them.
- R9: No more than `DEPTH` (default 4) requests are outstanding. With the queue full, no grant is given and `m_req` stays low.
- R10: Vector requests are still granted while vector instructions are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Scalar request valid |
| s_we | input | 1 | Scalar write enable |
| s_addr | input | 32 | Scalar address |
| s_wdata | input | 32 | Scalar write data |
| s_be | input | 4 | Scalar byte enables |
| s_gnt | output | 1 | Scalar request accepted |
| s_rvalid | output | 1 | Scalar response valid |
| s_rdata | output | 32 | Scalar response data |
| v_acc | input | 1 | Vector load/store instruction accepted (pulse) |
| v_req | input | 1 | Vector request valid |
| v_last | input | 1 | Request is the final one of its vector instruction |
| v_we | input | 1 | Vector write enable |
| v_addr | input | 32 | Vector address |
| v_wdata | input | 32 | Vector write data |
| v_be | input | 4 | Vector byte enables |
| v_gnt | output | 1 | Vector request accepted |
| v_rvalid | output | 1 | Vector response valid |
| v_rdata | output | 32 | Vector response data |
| m_req | output | 1 | Memory request valid |
| m_we | output | 1 | Memory write enable |
| m_addr | output | 32 | Memory address |
| m_wdata | output | 32 | Memory write data |
| m_be | output | 4 | Memory byte enables |
| m_rdy | input | 1 | Memory can accept a request this cycle |
| m_rvalid | input | 1 | Memory response valid (in order) |
| m_rdata | input | 32 | Memory response data |

## Verification
Grants and the forwarded request fields are combinational, so they are due in the cycle the request is driven. The bench drives inputs on the falling edge and samples one nanosecond later. Routed responses appear in the same cycle as `m_rvalid`, and the bench checks them in the cycle after the matching grant. The pending count is registered. A scalar request is therefore checked as blocked in the cycle after `v_acc`, and again during the cycle of the final vector response. It is checked as granted only in the following cycle.

// File: rtl/dmem_arb_pkg.sv
package dmem_arb_pkg;

    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;
    localparam int unsigned BW = DW / 8;

    typedef enum logic {
        SRC_SCALAR = 1'b0,
        SRC_VECTOR = 1'b1
    } src_e;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [BW-1:0] be;
    } mem_req_t;

    typedef struct packed {
        src_e src;
        logic last;
    } tag_t;

    function automatic mem_req_t pick_req(src_e sel, mem_req_t s, mem_req_t v);
        return (sel == SRC_VECTOR) ? v : s;
    endfunction

endpackage

// File: rtl/dmem_tag_fifo.sv
module dmem_tag_fifo
    import dmem_arb_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  tag_t push_tag,
    input  logic pop,
    output tag_t head,
    output logic full,
    output logic empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    tag_t          store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign full    = (fill == CW'(DEPTH));
    assign empty   = (fill == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                fill <= fill + 1'b1;
            end else if (do_pop && !do_push) begin
                fill <= fill - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_tag;
        end
    end

endmodule

// File: rtl/dmem_pend_track.sv
module dmem_pend_track #(
    parameter int unsigned MAX_INSN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic acc,
    input  logic done,
    output logic busy
);
    localparam int unsigned CW = $clog2(MAX_INSN + 1);

    logic [CW-1:0] cnt;
    logic          inc, dec;

    assign inc  = acc && (cnt != CW'(MAX_INSN));
    assign dec  = done && (cnt != '0);
    assign busy = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/dmem_arb_sel.sv
module dmem_arb_sel
    import dmem_arb_pkg::*;
(
    input  logic s_req,
    input  logic v_req,
    input  logic block_s,
    input  logic room,
    input  logic m_rdy,
    output src_e sel,
    output logic fwd,
    output logic s_gnt,
    output logic v_gnt
);
    logic s_ok;

    always_comb begin
        s_ok  = s_req && !block_s;
        sel   = v_req ? SRC_VECTOR : SRC_SCALAR;
        fwd   = room && (v_req || s_ok);
        v_gnt = fwd && m_rdy && v_req;
        s_gnt = fwd && m_rdy && !v_req;
    end

endmodule

// File: rtl/dmem_arbiter.sv
module dmem_arbiter
    import dmem_arb_pkg::*;
#(
    parameter int unsigned DEPTH    = 4,
    parameter int unsigned MAX_INSN = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        s_req,
    input  logic        s_we,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    input  logic [3:0]  s_be,
    output logic        s_gnt,
    output logic        s_rvalid,
    output logic [31:0] s_rdata,
    input  logic        v_acc,
    input  logic        v_req,
    input  logic        v_last,
    input  logic        v_we,
    input  logic [31:0] v_addr,
    input  logic [31:0] v_wdata,
    input  logic [3:0]  v_be,
    output logic        v_gnt,
    output logic        v_rvalid,
    output logic [31:0] v_rdata,
    output logic        m_req,
    output logic        m_we,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    output logic [3:0]  m_be,
    input  logic        m_rdy,
    input  logic        m_rvalid,
    input  logic [31:0] m_rdata
);
    mem_req_t s_pkt, v_pkt, m_pkt;
    src_e     sel;
    tag_t     new_tag, head;
    logic     fwd, full, empty, pop, busy, vec_done;

    assign s_pkt = '{we: s_we, addr: s_addr, wdata: s_wdata, be: s_be};
    assign v_pkt = '{we: v_we, addr: v_addr, wdata: v_wdata, be: v_be};

    dmem_arb_sel u_sel (
        .s_req   (s_req),
        .v_req   (v_req),
        .block_s (busy),
        .room    (!full),
        .m_rdy   (m_rdy),
        .sel     (sel),
        .fwd     (fwd),
        .s_gnt   (s_gnt),
        .v_gnt   (v_gnt)
    );

    assign m_pkt   = pick_req(sel, s_pkt, v_pkt);
    assign m_req   = fwd;
    assign m_we    = m_pkt.we;
    assign m_addr  = m_pkt.addr;
    assign m_wdata = m_pkt.wdata;
    assign m_be    = m_pkt.be;

    assign new_tag = '{src: sel, last: (sel == SRC_VECTOR) && v_last};

    dmem_tag_fifo #(.DEPTH(DEPTH)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .push     (s_gnt || v_gnt),
        .push_tag (new_tag),
        .pop      (pop),
        .head     (head),
        .full     (full),
        .empty    (empty)
    );

    assign pop      = m_rvalid && !empty;
    assign s_rvalid = pop && (head.src == SRC_SCALAR);
    assign v_rvalid = pop && (head.src == SRC_VECTOR);
    assign s_rdata  = s_rvalid ? m_rdata : '0;
    assign v_rdata  = v_rvalid ? m_rdata : '0;
    assign vec_done = v_rvalid && head.last;

    dmem_pend_track #(.MAX_INSN(MAX_INSN)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .acc  (v_acc),
        .done (vec_done),
        .busy (busy)
    );

endmodule

// File: rtl/dmem_arbiter_chk.sv
module dmem_arbiter_chk #(
    parameter int unsigned DEPTH = 4
) (
    input logic clk,
    input logic rst,
    input logic s_req,
    input logic v_req,
    input logic v_acc,
    input logic s_gnt,
    input logic v_gnt,
    input logic m_rdy,
    input logic m_req,
    input logic m_rvalid,
    input logic s_rvalid,
    input logic v_rvalid
);
    logic [7:0] outstanding;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= '0;
        end else begin
            outstanding <= outstanding + 8'(s_gnt || v_gnt) - 8'(s_rvalid || v_rvalid);
        end
    end

    p_gnt_needs_rdy_r3: assert property (@(posedge clk) disable iff (rst)
        (s_gnt || v_gnt) |-> (m_rdy && m_req));

    p_single_gnt_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({s_gnt, v_gnt}));

    p_vec_first_r4: assert property (@(posedge clk) disable iff (rst)
        s_gnt |-> !v_req);

    p_acc_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        v_acc |=> !s_gnt);

    p_rsp_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({s_rvalid, v_rvalid}));

    p_rsp_from_mem_r7: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid || v_rvalid) |-> (m_rvalid && outstanding != 8'd0));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        outstanding <= 8'(DEPTH));

    p_vec_served_r10: assert property (@(posedge clk) disable iff (rst)
        (v_req && m_rdy && outstanding < 8'(DEPTH)) |-> v_gnt);

    p_no_idle_fwd_r2: assert property (@(posedge clk) disable iff (rst)
        (!s_req && !v_req) |-> !m_req);

endmodule

bind dmem_arbiter dmem_arbiter_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .s_req    (s_req),
    .v_req    (v_req),
    .v_acc    (v_acc),
    .s_gnt    (s_gnt),
    .v_gnt    (v_gnt),
    .m_rdy    (m_rdy),
    .m_req    (m_req),
    .m_rvalid (m_rvalid),
    .s_rvalid (s_rvalid),
    .v_rvalid (v_rvalid)
);

// File: tb/test_dmem_arbiter.sv
`timescale 1ns/1ps
module test_dmem_arbiter;

    logic        clk = 1'b0;
    logic        rst;
    logic        s_req, s_we, s_gnt, s_rvalid;
    logic [31:0] s_addr, s_wdata, s_rdata;
    logic [3:0]  s_be;
    logic        v_acc, v_req, v_last, v_we, v_gnt, v_rvalid;
    logic [31:0] v_addr, v_wdata, v_rdata;
    logic [3:0]  v_be;
    logic        m_req, m_we, m_rdy, m_rvalid;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic [3:0]  m_be;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #4 clk = ~clk;

    dmem_arbiter i_dmem_arbiter (
        .clk(clk), .rst(rst),
        .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_be(s_be),
        .s_gnt(s_gnt), .s_rvalid(s_rvalid), .s_rdata(s_rdata),
        .v_acc(v_acc), .v_req(v_req), .v_last(v_last), .v_we(v_we), .v_addr(v_addr),
        .v_wdata(v_wdata), .v_be(v_be), .v_gnt(v_gnt), .v_rvalid(v_rvalid), .v_rdata(v_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
        .m_rdy(m_rdy), .m_rvalid(m_rvalid), .m_rdata(m_rdata)
    );

    // columns: s_req v_req m_rdy | expected s_gnt v_gnt
    localparam logic [4:0] TBL [8] = '{
        5'b001_00, 5'b101_10, 5'b011_01, 5'b111_01,
        5'b100_00, 5'b010_00, 5'b110_00, 5'b000_00
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        s_req = 0; s_we = 0; s_addr = 0; s_wdata = 0; s_be = 0;
        v_acc = 0; v_req = 0; v_last = 0; v_we = 0; v_addr = 0; v_wdata = 0; v_be = 0;
        m_rdy = 1; m_rvalid = 0; m_rdata = 0;
    endtask

    task automatic respond(input logic [31:0] d, input logic exp_s);
        @(negedge clk);
        idle();
        m_rvalid = 1; m_rdata = d;
        #1;
        chk("R7 s_rvalid", 32'(s_rvalid), 32'(exp_s));
        chk("R7 v_rvalid", 32'(v_rvalid), 32'(!exp_s));
        chk("R7 s_rdata", s_rdata, exp_s ? d : 32'h0);
        chk("R7 v_rdata", v_rdata, exp_s ? 32'h0 : d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: empty queue, response ignored
        m_rvalid = 1; m_rdata = 32'hdead0001;
        #1;
        chk("R1 s_rvalid empty", 32'(s_rvalid), 0);
        chk("R1 v_rvalid empty", 32'(v_rvalid), 0);
        @(negedge clk);
        idle();
        s_req = 1; s_addr = 32'h40;
        #1;
        chk("R1 scalar granted after reset", 32'(s_gnt), 1);
        respond(32'h11, 1'b1);

        // table walk: R2, R3, R4
        foreach (TBL[i]) begin
            @(negedge clk);
            idle();
            s_req = TBL[i][4]; v_req = TBL[i][3]; m_rdy = TBL[i][2];
            s_addr = 32'h1000 + i; v_addr = 32'h2000 + i;
            s_we = 1; v_we = 0; s_wdata = 32'hA000 + i; v_wdata = 32'hB000 + i;
            s_be = 4'h3; v_be = 4'hC;
            #1;
            chk("R3/R4 s_gnt", 32'(s_gnt), 32'(TBL[i][1]));
            chk("R3/R4 v_gnt", 32'(v_gnt), 32'(TBL[i][0]));
            if (TBL[i][1]) begin
                chk("R2 addr", m_addr, 32'h1000 + i);
                chk("R2 wdata", m_wdata, 32'hA000 + i);
                chk("R2 we/be", {27'h0, m_we, m_be}, {27'h0, 1'b1, 4'h3});
                chk("R2 m_req", 32'(m_req), 1);
            end
            if (TBL[i][0]) begin
                chk("R2 addr", m_addr, 32'h2000 + i);
                chk("R2 wdata", m_wdata, 32'hB000 + i);
                chk("R2 we/be", {27'h0, m_we, m_be}, {27'h0, 1'b0, 4'hC});
            end
            if (TBL[i][1] || TBL[i][0]) respond(32'h5000 + i, TBL[i][1]);
        end

        // R5/R6/R10: single vector instruction
        @(negedge clk);
        idle(); v_acc = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            idle(); s_req = 1; s_addr = 32'h300;
            #1;
            chk("R6 scalar held in gap", 32'(s_gnt), 0);
            chk("R6 no forward in gap", 32'(m_req), 0);
        end
        @(negedge clk);
        idle(); s_req = 1; v_req = 1; v_last = 1; v_addr = 32'h700;
        #1;
        chk("R10 vector granted while pending", 32'(v_gnt), 1);
        chk("R5 scalar held", 32'(s_gnt), 0);
        @(negedge clk);
        idle(); s_req = 1; m_rvalid = 1; m_rdata = 32'h77;
        #1;
        chk("R7 vector response", 32'(v_rvalid), 1);
        chk("R5 scalar held on final response", 32'(s_gnt), 0);
        @(negedge clk);
        idle(); s_req = 1;
        #1;
        chk("R5 scalar released", 32'(s_gnt), 1);
        respond(32'h88, 1'b1);

        // R8: two instructions in flight
        @(negedge clk); idle(); v_acc = 1;
        @(negedge clk); idle(); v_acc = 1;
        @(negedge clk); idle(); v_req = 1; v_last = 1;
        @(negedge clk); idle(); v_req = 1; v_last = 1;
        @(negedge clk); idle(); m_rvalid = 1;
        @(negedge clk); idle(); m_rvalid = 1; s_req = 1;
        #1;
        chk("R8 scalar held until all done", 32'(s_gnt), 0);
        @(negedge clk); idle(); s_req = 1;
        #1;
        chk("R8 scalar released", 32'(s_gnt), 1);
        respond(32'h99, 1'b1);

        // R9: queue full
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); idle(); s_req = 1; s_addr = 32'h900 + k;
            #1;
            chk("R9 fill grant", 32'(s_gnt), 1);
        end
        @(negedge clk); idle(); s_req = 1; v_req = 1;
        #1;
        chk("R9 full no scalar grant", 32'(s_gnt), 0);
        chk("R9 full no vector grant", 32'(v_gnt), 0);
        chk("R9 full no forward", 32'(m_req), 0);
        for (int k = 0; k < 4; k++) respond(32'hC0 + k, 1'b1);

        // R7: mixed order
        @(negedge clk); idle(); s_req = 1;
        @(negedge clk); idle(); v_req = 1;
        @(negedge clk); idle(); s_req = 1;
        respond(32'hA1, 1'b1);
        respond(32'hB2, 1'b0);
        respond(32'hC3, 1'b1);

        @(negedge clk); idle();
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule